// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block chooses the address of the next microinstruction in every clock cycle. It holds a microprogram counter and a five-entry return stack with its own pointer. It also holds a 12-bit counter that counts down and can be loaded from the data bus. A four-way selector drives the address output from one of four places: the data bus, the top of the stack, the counter, or the microprogram counter. A 4-bit operation code and a qualified condition decide which source is used and how the stack and the counter change.

Use it in front of a microcode store. The address output feeds the store. The data bus carries branch targets, mapping addresses or vector addresses from the pipeline. A three-wire one-hot source-enable output tells the surrounding logic which of these three must drive the data bus. At each clock edge the microprogram counter takes the current address plus the carry input, so the carry input either steps the address forward or holds it.

Top module: `useq_top`

## Requirements
- R1: While `rst_n` is low, `addrOut` is 0, `stackFull` is 0, the stack is empty and the counter is 0. Reset is asynchronous and active low.
- R2: At each rising edge the microprogram counter (PC) loads `addrOut + carryIn`. Operation 14 (continue) outputs PC, so with `carryIn` at 0 the address holds.
- R3: The condition passes when `condEn` is 0 or `condIn` is 1. It fails only when `condEn` is 1 and `condIn` is 0.
- R4: Operation 0 outputs address 0 and empties the stack.
- R5: Operation 2 outputs the data bus. Operations 3 and 6 output the data bus on pass and PC on fail. `srcEn` is one-hot: bit 1 for operation 2, bit 2 for operation 6, and bit 0 for every other operation.
- R6: Operation 1 on pass outputs the data bus and pushes PC. On fail it outputs PC and leaves the stack unchanged. Operation 10 on pass outputs the stack top and pops. On fail it outputs PC.
- R7: `stackFull` is 1 exactly when five entries are in use. A push while the stack is full overwrites the top entry. A pop on an empty stack leaves it empty.
- R8: Operation 4 outputs PC and pushes PC, and on pass it loads the counter from the data bus. Operation 12 outputs PC and always loads the counter.
- R9: Operation 5 always pushes PC and outputs the data bus on pass or the counter on fail. Operation 7 outputs the data bus on pass or the counter on fail, with no push.
- R10: Operation 8 with a nonzero counter outputs the stack top and decrements the counter. With a zero counter it outputs PC and pops. Operation 9 with a nonzero counter outputs the data bus and decrements. With a zero counter it outputs PC.
- R11: Operation 11 on pass outputs the data bus and pops. On fail it outputs PC. Operation 13 on pass outputs PC and pops. On fail it outputs the stack top.
- R12: Operation 15 with a nonzero counter decrements the counter. It outputs PC and pops on pass, or outputs the stack top on fail. With a zero counter it pops and outputs PC on pass, or the data bus on fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opCode | input | 4 | Next-address operation |
| condIn | input | 1 | Test condition, high is true |
| condEn | input | 1 | Condition qualifier; when low the condition always passes |
| dataIn | input | 12 | Branch, map or vector address bus |
| carryIn | input | 1 | Added to the output address when PC is loaded |
| addrOut | output | 12 | Next microinstruction address |
| stackFull | output | 1 | Five stack entries in use |
| srcEn | output | 3 | One-hot data-bus source enable: pipeline, map, vector |

## Verification
`addrOut` and `srcEn` are combinational functions of the inputs and the stored state, so they are due in the same cycle as the operation that selects them. The bench drives inputs at the falling edge and samples these outputs two nanoseconds later. The effects on PC, the stack pointer, the stack contents and the counter appear only after the next rising edge. A bench model applies the same operation at that edge and uses the result as its prediction for the following operation. `stackFull` follows the pointer, so it is compared one cycle after the push or pop that changed it.

// File: rtl/useq_pkg.sv
package useq_pkg;

  typedef enum logic [3:0] {
    OP_ZERO   = 4'd0,
    OP_CALL   = 4'd1,
    OP_MAP    = 4'd2,
    OP_JUMP   = 4'd3,
    OP_PUSH   = 4'd4,
    OP_CALLRC = 4'd5,
    OP_VECT   = 4'd6,
    OP_JUMPRC = 4'd7,
    OP_LOOPST = 4'd8,
    OP_LOOPDB = 4'd9,
    OP_RET    = 4'd10,
    OP_JPOP   = 4'd11,
    OP_LDCNT  = 4'd12,
    OP_TESTEND= 4'd13,
    OP_CONT   = 4'd14,
    OP_TWOWAY = 4'd15
  } opE;

  typedef enum logic [1:0] {
    SRC_DATA = 2'd0,
    SRC_TOP  = 2'd1,
    SRC_CNT  = 2'd2,
    SRC_PC   = 2'd3
  } srcE;

  typedef struct packed {
    srcE  ySel;
    logic zero;
    logic push;
    logic pop;
    logic clr;
    logic ldCnt;
    logic decCnt;
  } strobeT;

endpackage

// File: rtl/useq_ctrl.sv
module useq_ctrl
  import useq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] opCode,
  input  logic       condIn,
  input  logic       condEn,
  input  logic       cntZero,
  output strobeT     strb,
  output logic [2:0] srcEn
);

  logic pass;
  opE   op;

  assign pass = !condEn || condIn;
  assign op   = opE'(opCode);

  always_comb begin
    strb = '{ySel: SRC_PC, zero: 1'b0, push: 1'b0, pop: 1'b0,
             clr: 1'b0, ldCnt: 1'b0, decCnt: 1'b0};
    unique case (op)
      OP_ZERO: begin strb.zero = 1'b1; strb.clr = 1'b1; end
      OP_CALL: if (pass) begin strb.ySel = SRC_DATA; strb.push = 1'b1; end
      OP_MAP:  strb.ySel = SRC_DATA;
      OP_JUMP: if (pass) strb.ySel = SRC_DATA;
      OP_PUSH: begin strb.push = 1'b1; strb.ldCnt = pass; end
      OP_CALLRC: begin
        strb.ySel = pass ? SRC_DATA : SRC_CNT;
        strb.push = 1'b1;
      end
      OP_VECT:   if (pass) strb.ySel = SRC_DATA;
      OP_JUMPRC: strb.ySel = pass ? SRC_DATA : SRC_CNT;
      OP_LOOPST: begin
        if (!cntZero) begin strb.ySel = SRC_TOP; strb.decCnt = 1'b1; end
        else strb.pop = 1'b1;
      end
      OP_LOOPDB: if (!cntZero) begin strb.ySel = SRC_DATA; strb.decCnt = 1'b1; end
      OP_RET:  if (pass) begin strb.ySel = SRC_TOP; strb.pop = 1'b1; end
      OP_JPOP: if (pass) begin strb.ySel = SRC_DATA; strb.pop = 1'b1; end
      OP_LDCNT: strb.ldCnt = 1'b1;
      OP_TESTEND: begin
        if (pass) strb.pop = 1'b1;
        else strb.ySel = SRC_TOP;
      end
      OP_CONT: ;
      OP_TWOWAY: begin
        strb.decCnt = !cntZero;
        if (pass) strb.pop = 1'b1;
        else if (!cntZero) strb.ySel = SRC_TOP;
        else begin strb.ySel = SRC_DATA; strb.pop = 1'b1; end
      end
      default: ;
    endcase
  end

  always_comb begin
    srcEn = 3'b001;
    if (op == OP_MAP) srcEn = 3'b010;
    else if (op == OP_VECT) srcEn = 3'b100;
  end

  // R5: exactly one bus source enabled
  p_src_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(srcEn) == 1);
  // R7: never push and pop together
  p_no_push_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.push && strb.pop));
  // R10: never decrement a zero counter
  p_dec_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    strb.decCnt |-> !cntZero);

endmodule

// File: rtl/useq_dp.sv
module useq_dp
  import useq_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DEPTH = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  strobeT        strb,
  input  logic [AW-1:0] dataIn,
  input  logic          carryIn,
  output logic [AW-1:0] addrOut,
  output logic          stackFull,
  output logic          cntZero
);

  localparam int PW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] FULLV = PW'(DEPTH);

  logic [AW-1:0] pc, cnt, top, ySel;
  logic [AW-1:0] stk [DEPTH];
  logic [PW-1:0] sp;

  assign top     = (sp == '0) ? '0 : stk[sp - PW'(1)];
  assign cntZero = (cnt == '0);
  assign stackFull = (sp == FULLV);

  always_comb begin
    unique case (strb.ySel)
      SRC_DATA: ySel = dataIn;
      SRC_TOP:  ySel = top;
      SRC_CNT:  ySel = cnt;
      default:  ySel = pc;
    endcase
  end

  assign addrOut = (!rst_n || strb.zero) ? '0 : ySel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= addrOut + AW'(carryIn);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (strb.ldCnt)     cnt <= dataIn;
    else if (strb.decCnt)    cnt <= cnt - AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp <= '0;
    else if (strb.clr) sp <= '0;
    else if (strb.push && !stackFull) sp <= sp + PW'(1);
    else if (strb.pop && sp != '0) sp <= sp - PW'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_stk
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stk[i] <= '0;
      else if (strb.push && !strb.clr &&
               ((!stackFull && sp == PW'(i)) || (stackFull && i == DEPTH - 1)))
        stk[i] <= pc;
    end
  end

  // R7: pointer never exceeds the depth
  p_ptr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= FULLV);
  // R7: pop on empty stays empty
  p_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.pop && sp == '0 && !strb.push) |=> sp == '0);
  // R4: clear empties the stack
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clr |=> sp == '0);
  // R10: decrement lowers the counter by one
  p_cnt_dec_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.decCnt && !strb.ldCnt) |=> cnt == $past(cnt) - AW'(1));
  // R2: PC follows the previous address plus carry
  p_pc_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pc == $past(addrOut) + AW'($past(carryIn)));

endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DEPTH = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    opCode,
  input  logic          condIn,
  input  logic          condEn,
  input  logic [AW-1:0] dataIn,
  input  logic          carryIn,
  output logic [AW-1:0] addrOut,
  output logic          stackFull,
  output logic [2:0]    srcEn
);

  strobeT strb;
  logic   cntZero;

  useq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .opCode(opCode), .condIn(condIn),
    .condEn(condEn), .cntZero(cntZero), .strb(strb), .srcEn(srcEn)
  );

  useq_dp #(.AW(AW), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .dataIn(dataIn),
    .carryIn(carryIn), .addrOut(addrOut), .stackFull(stackFull),
    .cntZero(cntZero)
  );

  // R4: operation 0 gives address zero
  always_comb begin
    if (rst_n && opCode == 4'd0) a_zero_r4: assert (addrOut == '0);
  end

endmodule

// File: tb/sim_useq_top.sv
module sim_useq_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  opCode;
  logic        condIn, condEn, carryIn;
  logic [11:0] dataIn;
  logic [11:0] addrOut;
  logic        stackFull;
  logic [2:0]  srcEn;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [11:0] pcM, cntM;
  logic [11:0] stkM [5];
  int          spM;

  useq_top u0 (
    .clk(clk), .rst_n(rst_n), .opCode(opCode), .condIn(condIn),
    .condEn(condEn), .dataIn(dataIn), .carryIn(carryIn),
    .addrOut(addrOut), .stackFull(stackFull), .srcEn(srcEn)
  );

  always #5 clk = ~clk;

  function automatic string reqOf(input logic [3:0] op);
    case (op)
      4'd0: return "R4";
      4'd1, 4'd10: return "R6";
      4'd2, 4'd3, 4'd6: return "R5";
      4'd4, 4'd12: return "R8";
      4'd5, 4'd7: return "R9";
      4'd8, 4'd9: return "R10";
      4'd11, 4'd13: return "R11";
      4'd15: return "R12";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [11:0] topM();
    return (spM == 0) ? 12'd0 : stkM[spM-1];
  endfunction

  function automatic logic [11:0] expAddr(input logic [3:0] op, input bit p,
                                          input logic [11:0] d);
    bit z = (cntM == 0);
    case (op)
      4'd0: return 12'd0;
      4'd1, 4'd3, 4'd6, 4'd11: return p ? d : pcM;
      4'd2: return d;
      4'd5, 4'd7: return p ? d : cntM;
      4'd8: return z ? pcM : topM();
      4'd9: return z ? pcM : d;
      4'd10: return p ? topM() : pcM;
      4'd13: return p ? pcM : topM();
      4'd15: return p ? pcM : (z ? d : topM());
      default: return pcM;
    endcase
  endfunction

  task automatic pushM();
    if (spM == 5) stkM[4] = pcM;
    else begin stkM[spM] = pcM; spM++; end
  endtask

  task automatic popM();
    if (spM > 0) spM--;
  endtask

  task automatic updM(input logic [3:0] op, input bit p, input logic [11:0] d,
                      input logic [11:0] y, input logic ci);
    bit z = (cntM == 0);
    case (op)
      4'd0: spM = 0;
      4'd1: if (p) pushM();
      4'd4: begin pushM(); if (p) cntM = d; end
      4'd5: pushM();
      4'd8: if (!z) cntM--; else popM();
      4'd9: if (!z) cntM--;
      4'd10, 4'd11, 4'd13: if (p) popM();
      4'd12: cntM = d;
      4'd15: begin
        if (!z) cntM--;
        if (p || z) popM();
      end
      default: ;
    endcase
    pcM = y + {11'd0, ci};
  endtask

  task automatic chk(input string req, input string what,
                     input logic [11:0] act, input logic [11:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] op, input bit ce, input bit c,
                      input logic [11:0] d, input bit ci);
    bit p;
    logic [11:0] y;
    opCode = op; condEn = ce; condIn = c; dataIn = d; carryIn = ci;
    #2;
    p = !ce || c;
    y = expAddr(op, p, d);
    chk(reqOf(op), "addr", addrOut, y);
    chk("R7", "full", {11'd0, stackFull}, {11'd0, spM == 5});
    chk("R5", "srcEn", {9'd0, srcEn},
        {9'd0, (op == 4'd2) ? 3'b010 : (op == 4'd6) ? 3'b100 : 3'b001});
    @(posedge clk);
    updM(op, p, d, y, ci);
    @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=<100000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; opCode = 4'd14; condIn = 1'b0; condEn = 1'b0;
    dataIn = 12'hABC; carryIn = 1'b1;
    pcM = 0; cntM = 0; spM = 0;
    for (int i = 0; i < 5; i++) stkM[i] = 0;
    repeat (3) @(negedge clk);
    #2;
    chk("R1", "reset addr", addrOut, 12'd0);
    chk("R1", "reset full", {11'd0, stackFull}, 12'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: carry low holds, carry high steps
    step(4'd3, 0, 0, 12'h100, 1);
    step(4'd14, 0, 0, 0, 0);
    step(4'd14, 0, 0, 0, 1);
    step(4'd14, 0, 0, 0, 1);
    // R3: enabled condition false fails, true passes
    step(4'd3, 1, 0, 12'h222, 1);
    step(4'd3, 1, 1, 12'h333, 1);
    // R7: overfill, then overdrain
    for (int i = 0; i < 7; i++) step(4'd1, 0, 0, 12'h040 + 12'(i), 1);
    for (int i = 0; i < 7; i++) step(4'd10, 0, 1, 0, 1);
    // R10: repeat loop from counter 3 down to fall-through
    step(4'd12, 0, 0, 12'd3, 1);
    for (int i = 0; i < 5; i++) step(4'd9, 0, 0, 12'h500, 1);
    // R10/R12: stack loops
    step(4'd4, 0, 0, 12'd2, 1);
    for (int i = 0; i < 4; i++) step(4'd8, 0, 0, 0, 1);
    step(4'd4, 1, 1, 12'd1, 1);
    step(4'd15, 1, 0, 12'h777, 1);
    step(4'd15, 1, 0, 12'h778, 1);
    step(4'd0, 0, 0, 0, 1);

    for (int i = 0; i < 600; i++) begin
      logic [3:0] op = 4'($urandom % 16);
      if (op == 4'd0 && ($urandom % 4) != 0) op = 4'd4;
      step(op, 1'($urandom), 1'($urandom), 12'($urandom),
           ($urandom % 8) != 0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule